// File: doc/BRIEF.md
# Multicycle 32-bit Word-Addressed Processor Core

This block is a small processor core that runs a 32-bit word-addressed instruction set through one memory port, making at most one memory access per clock. It holds sixteen general registers, of which register 0 is fixed at zero, and a separate program counter. Every instruction takes three states: fetch, decode and execute. The memory is expected to answer combinationally, so read data belongs to the address driven in the same cycle.

A single level-sensitive interrupt request line is sampled only at instruction boundaries, and only while the interrupt enable bit is set. When a request is taken, the core spends the boundary cycle without fetching. It then pulses an acknowledge strobe for one cycle and reads a device index from the data bus during that cycle. Next it reads the handler address from the vector table word selected by that index, and resumes fetching there. The return address is kept in register 12. Words 0x00 to 0x0F are the vector table and execution starts at word 0x10 after reset.

Top module: `mc_core`

## Requirements
- R1: Synchronous active-low reset clears every register, sets PC to 0x10 and clears the interrupt enable. While reset is held, mem_addr is 0x10 and mem_we, irq_ack and halted are 0.
- R2: Each instruction uses three cycles: fetch (mem_addr = PC, the word read becomes the instruction, PC advances by one), decode and execute. mem_addr equals PC in every cycle except a lw/sw execute and the vector read.
- R3: The opcode sits in bits 31-28, register A in 27-24, register B in 23-20 and the R-type destination in 3-0. Opcode 0000 writes A+B to the destination and 0001 writes ~(A & B).
- R4: Opcode 0010 (addi) writes A plus the sign-extended 20-bit offset in bits 19-0 to register B.
- R5: Opcode 0011 (lw) loads register B from word A+offset. Opcode 0100 (sw) drives mem_addr = A+offset, mem_wdata = B and mem_we = 1 for exactly the execute cycle.
- R6: Register 0 reads as zero; a write to it has no effect.
- R7: Opcode 0101 (beq) sets PC to (beq address + 1) + offset when A equals B, and otherwise continues at the next word.
- R8: Opcode 0110 (jalr) writes the address of the following word into B and then jumps to the value of A. When A and B name the same nonzero register, it continues at the following word.
- R9: Opcode 1010 sets the interrupt enable and 1011 clears it. Opcode 1100 loads PC from register 12 and sets the enable in the same step.
- R10: Opcode 0111 (halt) stops the core for good. From the next cycle halted is 1, mem_we and irq_ack stay 0, and mem_addr holds still.
- R11: When a request is present at a fetch boundary with the enable set, no word is fetched in that cycle. In the next cycle irq_ack is 1 for one cycle, the index is taken from data bus bits 3-0, PC is saved in register 12 and the enable is cleared. In the cycle after that, mem_addr is the index and the word read becomes PC.
- R12: Opcodes 1000, 1001 and 1101 to 1111 change no state and execution goes on at the next word.
- R13: A request while the enable is clear is ignored, and no acknowledge is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 32 | Word address for the memory port |
| mem_wdata | output | 32 | Store data, valid while mem_we is 1 |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Read data; carries the device index during irq_ack |
| irq_req | input | 1 | Level interrupt request |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| halted | output | 1 | Core has executed halt |

## Verification
The fetch address is due in the fetch cycle itself, and load, store and interrupt effects are due in fixed slots after it. A store shows on the port in the execute cycle, two cycles after its fetch. The acknowledge comes one cycle after the boundary where the request was seen, and the vector address one cycle after that. Register results become visible only through later stores, so the bench compares every port against a behavioural model once per clock, 1 ns after the falling edge. It also checks the stored words after halt against hand-computed values.

// File: rtl/mc_core_pkg.sv
// Package mc_core_pkg
// Shared constants and enumerations for the multicycle core: instruction
// field positions, opcode codes and the control encodings passed from the
// sequencer to the datapath. Assumes 32-bit instructions.
package mc_core_pkg;

    localparam int OP_HI   = 31;
    localparam int OP_LO   = 28;
    localparam int RA_HI   = 27;
    localparam int RA_LO   = 24;
    localparam int RB_HI   = 23;
    localparam int RB_LO   = 20;
    localparam int RD_HI   = 3;
    localparam int RD_LO   = 0;
    localparam int IMM_W   = 20;

    localparam logic [3:0] OP_ADD  = 4'b0000;
    localparam logic [3:0] OP_NAND = 4'b0001;
    localparam logic [3:0] OP_ADDI = 4'b0010;
    localparam logic [3:0] OP_LW   = 4'b0011;
    localparam logic [3:0] OP_SW   = 4'b0100;
    localparam logic [3:0] OP_BEQ  = 4'b0101;
    localparam logic [3:0] OP_JALR = 4'b0110;
    localparam logic [3:0] OP_HALT = 4'b0111;
    localparam logic [3:0] OP_EI   = 4'b1010;
    localparam logic [3:0] OP_DI   = 4'b1011;
    localparam logic [3:0] OP_RETI = 4'b1100;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_IACK, ST_IVEC, ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        PCS_INC, PCS_BRANCH, PCS_REGA, PCS_MEM
    } pc_src_e;

    typedef enum logic [1:0] {
        AS_PC, AS_ALU, AS_VEC
    } addr_src_e;

    typedef enum logic [1:0] {
        WA_DST, WA_RB, WA_TRAP
    } wr_addr_e;

    typedef enum logic [1:0] {
        WD_ALU, WD_MEM, WD_PC
    } wr_data_e;

endpackage

// File: rtl/mc_regfile.sv
// Module mc_regfile
// General register bank with two combinational read ports and one write
// port. Entry 0 is built as a constant zero, so writes to it vanish.
// Assumes NREGS is a power of two; synchronous active-low reset.
module mc_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_a_addr,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] bank [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign bank[i] = '0;
        end else begin : g_live
            logic [DATA_W-1:0] q;
            // Hold one register, cleared by reset, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && wr_addr == AW'(i)) begin
                    q <= wr_data;
                end
            end
            assign bank[i] = q;
        end
    end

    // Read ports are plain array lookups.
    always_comb begin
        rd_a_data = bank[rd_a_addr];
        rd_b_data = bank[rd_b_addr];
    end

endmodule

// File: rtl/mc_alu.sv
// Module mc_alu
// Two-function arithmetic unit (add or bitwise not-and) plus an
// equality flag for branch decisions. Purely combinational.
module mc_alu #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              nand_sel,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    output logic [DATA_W-1:0] result,
    output logic              equal
);

    // Select the arithmetic function.
    always_comb begin
        if (nand_sel) begin
            result = ~(opa & opb);
        end else begin
            result = opa + opb;
        end
    end

    // Compare the two latched register values for beq.
    always_comb begin
        equal = (cmp_a == cmp_b);
    end

endmodule

// File: rtl/mc_ctrl.sv
// Module mc_ctrl
// Sequencer for the multicycle core. Steps fetch, decode and execute,
// inserts the two-cycle interrupt entry at a fetch boundary, and parks
// in a halt state. Owns the interrupt enable bit. Assumes the opcode
// input is stable from decode through execute.
module mc_ctrl
    import mc_core_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  opcode,
    input  logic        regs_equal,
    input  logic        same_nonzero,
    input  logic        irq_req,
    output seq_state_e  state,
    output logic        ir_load,
    output logic        ab_load,
    output logic        idx_load,
    output logic        pc_load,
    output pc_src_e     pc_src,
    output addr_src_e   addr_src,
    output logic        rf_we,
    output wr_addr_e    wa_sel,
    output wr_data_e    wd_sel,
    output logic        use_imm,
    output logic        alu_nand,
    output logic        mem_we,
    output logic        irq_ack,
    output logic        int_en,
    output logic        halted
);

    seq_state_e state_q, state_d;
    logic       ie_q, ie_set, ie_clr;

    // Advance the sequencer state and the interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            ie_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ie_clr) begin
                ie_q <= 1'b0;
            end else if (ie_set) begin
                ie_q <= 1'b1;
            end
        end
    end

    // Decode state and opcode into datapath controls and the next state.
    always_comb begin
        state_d  = state_q;
        ir_load  = 1'b0;
        ab_load  = 1'b0;
        idx_load = 1'b0;
        pc_load  = 1'b0;
        pc_src   = PCS_INC;
        addr_src = AS_PC;
        rf_we    = 1'b0;
        wa_sel   = WA_DST;
        wd_sel   = WD_ALU;
        use_imm  = 1'b0;
        alu_nand = 1'b0;
        mem_we   = 1'b0;
        irq_ack  = 1'b0;
        ie_set   = 1'b0;
        ie_clr   = 1'b0;
        case (state_q)
            ST_FETCH: begin
                if (ie_q && irq_req) begin
                    state_d = ST_IACK;
                end else begin
                    ir_load = 1'b1;
                    pc_load = 1'b1;
                    pc_src  = PCS_INC;
                    state_d = ST_DECODE;
                end
            end
            ST_DECODE: begin
                ab_load = 1'b1;
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                state_d = ST_FETCH;
                case (opcode)
                    OP_ADD, OP_NAND: begin
                        rf_we    = 1'b1;
                        wa_sel   = WA_DST;
                        wd_sel   = WD_ALU;
                        alu_nand = (opcode == OP_NAND);
                    end
                    OP_ADDI: begin
                        rf_we   = 1'b1;
                        wa_sel  = WA_RB;
                        wd_sel  = WD_ALU;
                        use_imm = 1'b1;
                    end
                    OP_LW: begin
                        use_imm  = 1'b1;
                        addr_src = AS_ALU;
                        rf_we    = 1'b1;
                        wa_sel   = WA_RB;
                        wd_sel   = WD_MEM;
                    end
                    OP_SW: begin
                        use_imm  = 1'b1;
                        addr_src = AS_ALU;
                        mem_we   = 1'b1;
                    end
                    OP_BEQ: begin
                        if (regs_equal) begin
                            pc_load = 1'b1;
                            pc_src  = PCS_BRANCH;
                        end
                    end
                    OP_JALR: begin
                        rf_we  = 1'b1;
                        wa_sel = WA_RB;
                        wd_sel = WD_PC;
                        if (!same_nonzero) begin
                            pc_load = 1'b1;
                            pc_src  = PCS_REGA;
                        end
                    end
                    OP_HALT: begin
                        state_d = ST_HALT;
                    end
                    OP_EI: begin
                        ie_set = 1'b1;
                    end
                    OP_DI: begin
                        ie_clr = 1'b1;
                    end
                    OP_RETI: begin
                        pc_load = 1'b1;
                        pc_src  = PCS_REGA;
                        ie_set  = 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
            ST_IACK: begin
                irq_ack  = 1'b1;
                idx_load = 1'b1;
                rf_we    = 1'b1;
                wa_sel   = WA_TRAP;
                wd_sel   = WD_PC;
                ie_clr   = 1'b1;
                state_d  = ST_IVEC;
            end
            ST_IVEC: begin
                addr_src = AS_VEC;
                pc_load  = 1'b1;
                pc_src   = PCS_MEM;
                state_d  = ST_FETCH;
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: begin
                state_d = ST_FETCH;
            end
        endcase
    end

    // Export registered status.
    always_comb begin
        state  = state_q;
        int_en = ie_q;
        halted = (state_q == ST_HALT);
    end

endmodule

// File: rtl/mc_core.sv
// Module mc_core
// Top of the multicycle core: instruction, program counter, operand and
// vector index registers, plus the address, write-back and next-PC
// multiplexers. Assumes a combinational memory on one shared port and a
// device index in the low VEC_W bits of the data bus while irq_ack is 1.
// Synchronous active-low reset.
module mc_core
    import mc_core_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          NREGS    = 16,
    parameter int          VEC_W    = 4,
    parameter int          TRAP_REG = 12,
    parameter logic [31:0] RESET_PC = 32'h0000_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              irq_req,
    output logic              irq_ack,
    output logic              halted
);

    localparam int AW = $clog2(NREGS);

    logic [DATA_W-1:0] ir_q, pc_q, a_q, b_q, pc_d;
    logic [VEC_W-1:0]  idx_q;
    logic [DATA_W-1:0] imm, rd_a, rd_b, alu_b, alu_res, wr_data;
    logic [AW-1:0]     ra_f, rb_f, rd_f, rd_a_addr, wr_addr;
    logic [3:0]        opcode;
    logic              regs_equal, same_nonzero;

    seq_state_e state;
    logic       ir_load, ab_load, idx_load, pc_load, rf_we;
    logic       use_imm, alu_nand, int_en;
    pc_src_e    pc_src;
    addr_src_e  addr_src;
    wr_addr_e   wa_sel;
    wr_data_e   wd_sel;

    // Split the held instruction into fields and the widened offset.
    always_comb begin
        opcode       = ir_q[OP_HI:OP_LO];
        ra_f         = ir_q[RA_HI:RA_LO];
        rb_f         = ir_q[RB_HI:RB_LO];
        rd_f         = ir_q[RD_HI:RD_LO];
        imm          = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
        same_nonzero = (ra_f == rb_f) && (ra_f != '0);
        rd_a_addr    = (opcode == OP_RETI) ? AW'(TRAP_REG) : ra_f;
    end

    mc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .opcode       (opcode),
        .regs_equal   (regs_equal),
        .same_nonzero (same_nonzero),
        .irq_req      (irq_req),
        .state        (state),
        .ir_load      (ir_load),
        .ab_load      (ab_load),
        .idx_load     (idx_load),
        .pc_load      (pc_load),
        .pc_src       (pc_src),
        .addr_src     (addr_src),
        .rf_we        (rf_we),
        .wa_sel       (wa_sel),
        .wd_sel       (wd_sel),
        .use_imm      (use_imm),
        .alu_nand     (alu_nand),
        .mem_we       (mem_we),
        .irq_ack      (irq_ack),
        .int_en       (int_en),
        .halted       (halted)
    );

    mc_regfile #(
        .DATA_W (DATA_W),
        .NREGS  (NREGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_addr (rd_a_addr),
        .rd_b_addr (rb_f),
        .rd_a_data (rd_a),
        .rd_b_data (rd_b),
        .wr_en     (rf_we),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    // Second ALU operand is either register B or the offset.
    always_comb begin
        alu_b = use_imm ? imm : b_q;
    end

    mc_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .opa      (a_q),
        .opb      (alu_b),
        .nand_sel (alu_nand),
        .cmp_a    (a_q),
        .cmp_b    (b_q),
        .result   (alu_res),
        .equal    (regs_equal)
    );

    // Pick the register write target and value.
    always_comb begin
        case (wa_sel)
            WA_RB:   wr_addr = rb_f;
            WA_TRAP: wr_addr = AW'(TRAP_REG);
            default: wr_addr = rd_f;
        endcase
        case (wd_sel)
            WD_MEM:  wr_data = mem_rdata;
            WD_PC:   wr_data = pc_q;
            default: wr_data = alu_res;
        endcase
    end

    // Pick the next program counter value.
    always_comb begin
        case (pc_src)
            PCS_BRANCH: pc_d = pc_q + imm;
            PCS_REGA:   pc_d = a_q;
            PCS_MEM:    pc_d = mem_rdata;
            default:    pc_d = pc_q + DATA_W'(1);
        endcase
    end

    // Drive the memory port.
    always_comb begin
        case (addr_src)
            AS_ALU:  mem_addr = alu_res;
            AS_VEC:  mem_addr = {{(DATA_W-VEC_W){1'b0}}, idx_q};
            default: mem_addr = pc_q;
        endcase
        mem_wdata = b_q;
    end

    // Hold instruction, PC, operands and vector index across states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            pc_q  <= DATA_W'(RESET_PC);
            a_q   <= '0;
            b_q   <= '0;
            idx_q <= '0;
        end else begin
            if (ir_load) begin
                ir_q <= mem_rdata;
            end
            if (pc_load) begin
                pc_q <= pc_d;
            end
            if (ab_load) begin
                a_q <= rd_a;
                b_q <= rd_b;
            end
            if (idx_load) begin
                idx_q <= mem_rdata[VEC_W-1:0];
            end
        end
    end

endmodule

// File: rtl/mc_core_chk.sv
// Module mc_core_chk
// Port-level protocol checker for mc_core, bound to every instance.
// Observes the memory strobes, the acknowledge, halted and the internal
// interrupt enable. Assumes synchronous active-low reset.
module mc_core_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              irq_req,
    input logic              irq_ack,
    input logic              int_en,
    input logic              halted
);

    // R11: the acknowledge lasts one cycle.
    assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R11: the acknowledge follows a request seen at the previous boundary.
    assert_ack_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(irq_req));

    // R11: taking the interrupt clears the enable.
    assert_ack_clears_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !int_en);

    // R13: no acknowledge while interrupts are disabled.
    assert_ack_needs_en_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> int_en);

    // R5: a store strobe lasts exactly one cycle and never meets the ack.
    assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_we_not_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && irq_ack));

    // R10: halt is permanent, quiet and freezes the address.
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_we && !irq_ack));

    assert_halt_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr));

endmodule

bind mc_core mc_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .int_en   (int_en),
    .halted   (halted)
);

// File: tb/test_mc_core.sv
// Bench test_mc_core
// Runs a program against a behavioural instruction-level model that
// tracks the cycle phase, comparing every port once per clock.
module test_mc_core;

    localparam int PF = 0, PD = 1, PE = 2, PA = 3, PV = 4, PH = 5;
    localparam logic [31:0] DEV_IDX = 32'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, irq_req, irq_ack, halted;

    logic [31:0] mem [256];

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    assign mem_rdata = irq_ack ? DEV_IDX : mem[mem_addr[7:0]];

    mc_core i_mc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .irq_req   (irq_req),
        .irq_ack   (irq_ack),
        .halted    (halted)
    );

    function automatic logic [31:0] enc_r(int op, int a, int b, int d);
        return {op[3:0], a[3:0], b[3:0], 16'h0, d[3:0]};
    endfunction

    function automatic logic [31:0] enc_i(int op, int a, int b, int off);
        return {op[3:0], a[3:0], b[3:0], off[19:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model state
    logic [31:0] rf [16];
    logic [31:0] pc, ir, idx;
    int          ph;
    bit          ie, di_seen;

    task automatic wr(int r, logic [31:0] v);
        if (r != 0) rf[r] = v;
    endtask

    function automatic logic [31:0] sx(logic [31:0] w);
        return {{12{w[19]}}, w[19:0]};
    endfunction

    function automatic string tag_of(int p, logic [31:0] w);
        if (p == PF || p == PD) return "R2";
        if (p == PA || p == PV) return "R11";
        if (p == PH) return "R10";
        case (w[31:28])
            4'd0, 4'd1: return "R3";
            4'd2:       return "R4";
            4'd3, 4'd4: return "R5";
            4'd5:       return "R7";
            4'd6:       return "R8";
            4'd7:       return "R10";
            4'd10, 4'd11, 4'd12: return "R9";
            default:    return "R12";
        endcase
    endfunction

    initial begin
        int cyc, hcnt, acks;
        logic [31:0] e_addr, va, vb, off;
        logic        e_we, e_ack, e_halt;
        logic [3:0]  op;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        mem[3]    = 32'h60;
        mem[8'h10] = enc_i(2, 0, 2, 5);
        mem[8'h11] = enc_i(2, 0, 3, -3);
        mem[8'h12] = enc_r(0, 2, 3, 4);
        mem[8'h13] = enc_r(1, 2, 3, 5);
        mem[8'h14] = enc_i(4, 0, 4, 'h90);
        mem[8'h15] = enc_i(4, 0, 5, 'h91);
        mem[8'h16] = enc_i(3, 0, 6, 'h90);
        mem[8'h17] = enc_i(2, 0, 0, 7);
        mem[8'h18] = enc_i(4, 0, 0, 'h92);
        mem[8'h19] = enc_i(5, 2, 2, 1);
        mem[8'h1A] = enc_i(2, 0, 7, 99);
        mem[8'h1B] = enc_i(4, 0, 7, 'h93);
        mem[8'h1C] = enc_i(5, 2, 3, 1);
        mem[8'h1D] = enc_i(2, 6, 8, 9);
        mem[8'h1E] = enc_i(4, 0, 8, 'h94);
        mem[8'h1F] = enc_i(2, 0, 10, 'h23);
        mem[8'h20] = enc_i(6, 10, 9, 0);
        mem[8'h21] = enc_r(7, 0, 0, 0);
        mem[8'h22] = enc_r(7, 0, 0, 0);
        mem[8'h23] = enc_i(4, 0, 9, 'h95);
        mem[8'h24] = enc_i(6, 11, 11, 0);
        mem[8'h25] = enc_i(4, 0, 11, 'h96);
        mem[8'h26] = 32'h8000_0000;
        mem[8'h27] = 32'hF123_4567;
        mem[8'h28] = enc_r(10, 0, 0, 0);
        mem[8'h29] = enc_r(0, 0, 0, 0);
        mem[8'h2A] = enc_i(4, 0, 12, 'h97);
        mem[8'h2B] = enc_r(11, 0, 0, 0);
        mem[8'h2C] = enc_r(0, 0, 0, 0);
        mem[8'h2D] = enc_r(0, 0, 0, 0);
        mem[8'h2E] = enc_r(0, 0, 0, 0);
        mem[8'h2F] = enc_r(7, 0, 0, 0);
        mem[8'h60] = enc_i(2, 1, 1, 1);
        mem[8'h61] = enc_i(4, 0, 1, 'h80);
        mem[8'h62] = enc_r(12, 0, 0, 0);

        irq_req = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset addr", mem_addr, 32'h10);
        check("R1 reset strobes", {29'h0, mem_we, irq_ack, halted}, 32'h0);

        pc = 32'h10; ph = PF; ie = 1'b0; di_seen = 1'b0; ir = 32'h0; idx = 32'h0;
        cyc = 0; hcnt = 0; acks = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (hcnt <= 10 && cyc < 2000) begin
            cyc++;
            if (cyc == 5) irq_req = 1'b1;
            if (ph == PA) irq_req = 1'b0;
            if (di_seen) irq_req = 1'b1;
            #1;
            op = ir[31:28];
            va = rf[ir[27:24]];
            vb = rf[ir[23:20]];
            off = sx(ir);
            e_addr = pc; e_we = 1'b0; e_ack = 1'b0; e_halt = (ph == PH);
            if (ph == PE && (op == 4'd3 || op == 4'd4)) e_addr = va + off;
            if (ph == PE && op == 4'd4) e_we = 1'b1;
            if (ph == PA) e_ack = 1'b1;
            if (ph == PV) e_addr = DEV_IDX;
            check({tag_of(ph, ir), " addr"}, mem_addr, e_addr);
            check({tag_of(ph, ir), " strobes"}, {29'h0, mem_we, irq_ack, halted},
                  {29'h0, e_we, e_ack, e_halt});
            if (e_we) check("R5 store data", mem_wdata, vb);
            if (irq_ack) acks++;
            case (ph)
                PF: begin
                    if (ie && irq_req) ph = PA;
                    else begin ir = mem[pc[7:0]]; pc = pc + 1; ph = PD; end
                end
                PD: ph = PE;
                PE: begin
                    ph = PF;
                    case (op)
                        4'd0: wr(ir[3:0], va + vb);
                        4'd1: wr(ir[3:0], ~(va & vb));
                        4'd2: wr(ir[23:20], va + off);
                        4'd3: wr(ir[23:20], mem[8'(va + off)]);
                        4'd5: if (va == vb) pc = pc + off;
                        4'd6: begin wr(ir[23:20], pc); pc = rf[ir[27:24]]; end
                        4'd7: ph = PH;
                        4'd10: ie = 1'b1;
                        4'd11: begin ie = 1'b0; di_seen = 1'b1; end
                        4'd12: begin pc = rf[12]; ie = 1'b1; end
                        default: ;
                    endcase
                end
                PA: begin wr(12, pc); ie = 1'b0; ph = PV; end
                PV: begin pc = mem[DEV_IDX[7:0]]; ph = PF; end
                default: hcnt++;
            endcase
            if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            @(negedge clk);
        end
        if (cyc >= 2000) check("watchdog expired", 32'd1, 32'd0);

        check("R3 add result", mem[8'h90], 32'd2);
        check("R3 R4 nand result", mem[8'h91], 32'hFFFF_FFFA);
        check("R6 reg0 after write", mem[8'h92], 32'd0);
        check("R7 taken branch skipped", mem[8'h93], 32'd0);
        check("R5 R7 load then addi", mem[8'h94], 32'd11);
        check("R8 link value", mem[8'h95], 32'h21);
        check("R8 same register jalr", mem[8'h96], 32'h25);
        check("R9 R11 return address", mem[8'h97], 32'h29);
        check("R11 handler ran once", mem[8'h80], 32'd1);
        check("R13 ack count", acks, 32'd1);
        check("R12 reached halt", {31'h0, halted}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule